// File: doc/BRIEF.md
# Packed-Pixel Priority Write Port

This unit sits between a CPU-side byte/word port and a shared RAM of 16-bit words. Each word holds four 4-bit pixels. A byte write carries one pixel in its low nibble. The unit turns the write into a read-modify-write of that one nibble, so the other three pixels in the word are preserved.

A 2-bit priority mode, latched with each request, decides whether a pixel is committed:
- **Plain:** the pixel is always written.
- **Overwrite:** a zero pixel is transparent and is not written.
- **Underwrite:** only an empty position may be filled.

Reads go through the same port. They unpack two adjacent pixels into the low nibble of each byte of the returned word.

Every request takes three clock edges:
1. The first edge accepts the request.
2. The second edge performs the RAM read.
3. The third edge commits the write (or discards it), or registers the read data, and raises `done` for one cycle.

`busy` is high between acceptance and completion. Requests presented while `busy` is high are ignored.

Top module: `pixel_prio_port`

## Requirements
- R1: After reset, `busy`, `done` and `rdata` are all zero.
- R2: A request is accepted only when `busy` is low. After the accepting edge, `busy` stays high for exactly two cycles. On the third edge `busy` falls and `done` is high for exactly one cycle. Requests presented while `busy` is high are ignored.
- R3: A byte write (`req_word`=0) stores `req_wdata[3:0]` at position `req_addr[1:0]` of word `req_addr>>2`. Position n occupies bits [15-4n:12-4n]. `req_wdata[7:4]` and the other three positions are left unchanged.
- R4: A word write (`req_word`=1) acts as two byte writes to the same word. `req_wdata[11:8]` goes to the even position selected by `req_addr[1]`, and `req_wdata[3:0]` goes to the position after it. `req_addr[0]` and the data bits [15:12] and [7:4] are ignored.
- R5: Mode 2'b10 (overwrite) discards a pixel whose value is zero and writes any nonzero pixel.
- R6: Mode 2'b01 (underwrite) writes a pixel only when the new value is nonzero and the stored pixel at that position is zero.
- R7: Modes 2'b00 and 2'b11 write the pixel unconditionally, including zero.
- R8: A word read returns `{4'h0, pixel 2k, 4'h0, pixel 2k+1}`, where k = `req_addr[1]`.
- R9: A byte read returns the read word's high byte for an even address and its low byte for an odd address. The result is placed in `rdata[7:0]`, and `rdata[15:8]` is zero.
- R10: In a word write, each of the two pixels is judged by the priority rule on its own. One may commit while the other is discarded.
- R11: `rdata` changes only at the completion of a read. Write requests leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits [7:0] |
| prio_mode | input | 2 | 00 plain, 10 overwrite, 01 underwrite, 11 plain |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Formatted read data, held until the next read completes |

## Verification
A table of vectors first clears two words with plain writes. It then walks them through three kinds of sequence:
- Byte writes in every mode, each followed by word and byte reads. The reads separate the four nibble positions, the high/low byte selection, and the discarded upper data nibble.
- Overwrite and underwrite tried with both zero and nonzero new pixels, over both empty and occupied positions. This shows which of the two conditions blocks a commit.
- Word writes in which one lane commits and the other is discarded. These show that the lanes are judged independently and that address bit 0 is ignored.

Directed tests then check the cycle timing of `busy`/`done`, a request held through the busy window, and that `rdata` is unchanged across writes.

// File: rtl/pixel_prio_pkg.sv
package pixel_prio_pkg;
    localparam int PIX_W  = 4;
    localparam int LANES  = 4;
    localparam int WORD_W = PIX_W * LANES;

    typedef enum logic [1:0] {
        PRIO_PLAIN  = 2'b00,
        PRIO_UNDER  = 2'b01,
        PRIO_OVER   = 2'b10,
        PRIO_PLAIN2 = 2'b11
    } prio_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_MERGE = 2'd2
    } state_e;
endpackage

// File: rtl/pix_lane_filter.sv
module pix_lane_filter
    import pixel_prio_pkg::*;
(
    input  logic             en,
    input  prio_e            mode,
    input  logic [PIX_W-1:0] old_pix,
    input  logic [PIX_W-1:0] new_pix,
    output logic             commit,
    output logic [PIX_W-1:0] out_pix
);
    logic new_zero;
    logic old_zero;

    always_comb begin
        new_zero = (new_pix == '0);
        old_zero = (old_pix == '0);
        commit   = 1'b0;
        if (en) begin
            unique case (mode)
                PRIO_OVER:  commit = !new_zero;
                PRIO_UNDER: commit = !new_zero && old_zero;
                default:    commit = 1'b1;
            endcase
        end
        out_pix = commit ? new_pix : old_pix;
    end
endmodule

// File: rtl/pix_word_ram.sv
module pix_word_ram #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
        rdata <= mem[idx];
    end
endmodule

// File: rtl/pix_read_fmt.sv
module pix_read_fmt
    import pixel_prio_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic              pair_sel,
    input  logic              byte_acc,
    input  logic              odd,
    output logic [WORD_W-1:0] fmt_out
);
    logic [PIX_W-1:0]  first_pix;
    logic [PIX_W-1:0]  second_pix;
    logic [WORD_W-1:0] wide;

    always_comb begin
        first_pix  = pair_sel ? word_in[7:4] : word_in[15:12];
        second_pix = pair_sel ? word_in[3:0] : word_in[11:8];
        wide       = {4'h0, first_pix, 4'h0, second_pix};
        if (!byte_acc) begin
            fmt_out = wide;
        end else if (odd) begin
            fmt_out = {8'h00, wide[7:0]};
        end else begin
            fmt_out = {8'h00, wide[15:8]};
        end
    end
endmodule

// File: rtl/pixel_prio_port.sv
module pixel_prio_port
    import pixel_prio_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        prio_mode,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rdata
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        state_e              st;
        logic                wr;
        logic                wd;
        logic [ADDR_W-1:0]   addr;
        logic [PIX_W-1:0]    hi_pix;
        logic [PIX_W-1:0]    lo_pix;
        prio_e               mode;
        logic                done;
        logic [WORD_W-1:0]   rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic [WORD_W-1:0] ram_rdata;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] fmt_word;
    logic [LANES-1:0]  lane_commit;
    logic              ram_we;

    // Per-lane priority filtering of the stored word
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [1:0] LANE_POS = 2'(i);
        logic             lane_en;
        logic [PIX_W-1:0] lane_new;
        logic [PIX_W-1:0] lane_out;

        always_comb begin
            if (r_q.wd) begin
                lane_en  = (LANE_POS[1] == r_q.addr[1]);
                lane_new = LANE_POS[0] ? r_q.lo_pix : r_q.hi_pix;
            end else begin
                lane_en  = (LANE_POS == r_q.addr[1:0]);
                lane_new = r_q.lo_pix;
            end
        end

        pix_lane_filter u_filt (
            .en      (lane_en && r_q.wr),
            .mode    (r_q.mode),
            .old_pix (ram_rdata[WORD_W-1-PIX_W*i -: PIX_W]),
            .new_pix (lane_new),
            .commit  (lane_commit[i]),
            .out_pix (lane_out)
        );

        assign merged[WORD_W-1-PIX_W*i -: PIX_W] = lane_out;
    end

    pix_read_fmt u_fmt (
        .word_in  (ram_rdata),
        .pair_sel (r_q.addr[1]),
        .byte_acc (!r_q.wd),
        .odd      (r_q.addr[0]),
        .fmt_out  (fmt_word)
    );

    assign ram_we = (r_q.st == ST_MERGE) && r_q.wr && (|lane_commit);

    pix_word_ram #(
        .IDX_W  (IDX_W),
        .DATA_W (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (r_q.addr[ADDR_W-1:2]),
        .wdata (merged),
        .rdata (ram_rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st     = ST_READ;
                    r_d.wr     = req_write;
                    r_d.wd     = req_word;
                    r_d.addr   = req_addr;
                    r_d.hi_pix = req_wdata[11:8];
                    r_d.lo_pix = req_wdata[3:0];
                    r_d.mode   = prio_e'(prio_mode);
                end
            end
            ST_READ: begin
                r_d.st = ST_MERGE;
            end
            ST_MERGE: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                if (!r_q.wr) begin
                    r_d.rdata = fmt_word;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy  = (r_q.st != ST_IDLE);
    assign done  = r_q.done;
    assign rdata = r_q.rdata;
endmodule

// File: rtl/pixel_prio_port_chk.sv
module pixel_prio_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && req_valid) |=> busy); // R2
    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid) |=> busy); // R2
    AST_TWO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> (!busy && done)); // R2
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done); // R11
endmodule

bind pixel_prio_port pixel_prio_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata)
);

// File: tb/pixel_prio_port_test.sv
module pixel_prio_port_test;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    prio_mode = '0;
    logic          busy;
    logic          done;
    logic [15:0]   rdata;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pixel_prio_port #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .prio_mode(prio_mode), .busy(busy), .done(done), .rdata(rdata)
    );

    // {write, word, addr[9:0], wdata[15:0], mode[1:0], expected[15:0], tag[3:0]}
    localparam int NV = 31;
    localparam logic [49:0] TV [NV] = '{
        {1'b1, 1'b1, 10'd0, 16'h0000, 2'b00, 16'h0000, 4'd7},
        {1'b1, 1'b1, 10'd2, 16'h0000, 2'b00, 16'h0000, 4'd7},
        {1'b1, 1'b1, 10'd4, 16'h0000, 2'b00, 16'h0000, 4'd7},
        {1'b1, 1'b1, 10'd6, 16'h0000, 2'b00, 16'h0000, 4'd7},
        {1'b1, 1'b0, 10'd1, 16'h00F5, 2'b00, 16'h0000, 4'd3},
        {1'b1, 1'b0, 10'd0, 16'h0007, 2'b00, 16'h0000, 4'd3},
        {1'b0, 1'b1, 10'd0, 16'h0000, 2'b00, 16'h0705, 4'd3},  // R3 R8
        {1'b1, 1'b0, 10'd0, 16'h0000, 2'b10, 16'h0000, 4'd5},
        {1'b0, 1'b1, 10'd0, 16'h0000, 2'b00, 16'h0705, 4'd5},  // R5 zero discarded
        {1'b1, 1'b0, 10'd0, 16'h0003, 2'b10, 16'h0000, 4'd5},
        {1'b0, 1'b0, 10'd0, 16'h0000, 2'b00, 16'h0003, 4'd9},  // R9 even byte, R5
        {1'b0, 1'b0, 10'd1, 16'h0000, 2'b00, 16'h0005, 4'd9},  // R9 odd byte
        {1'b1, 1'b0, 10'd2, 16'h0009, 2'b01, 16'h0000, 4'd6},
        {1'b1, 1'b0, 10'd2, 16'h0004, 2'b01, 16'h0000, 4'd6},
        {1'b1, 1'b0, 10'd3, 16'h0000, 2'b01, 16'h0000, 4'd6},
        {1'b0, 1'b1, 10'd2, 16'h0000, 2'b00, 16'h0900, 4'd6},  // R6 R8
        {1'b1, 1'b0, 10'd3, 16'h000C, 2'b11, 16'h0000, 4'd7},
        {1'b0, 1'b0, 10'd3, 16'h0000, 2'b00, 16'h000C, 4'd7},  // R7 mode 11 writes
        {1'b1, 1'b0, 10'd3, 16'h0000, 2'b11, 16'h0000, 4'd7},
        {1'b1, 1'b0, 10'd2, 16'h0000, 2'b00, 16'h0000, 4'd7},
        {1'b0, 1'b1, 10'd2, 16'h0000, 2'b00, 16'h0000, 4'd7},  // R7 zero written
        {1'b1, 1'b1, 10'd4, 16'hFAFB, 2'b00, 16'h0000, 4'd4},
        {1'b0, 1'b1, 10'd4, 16'h0000, 2'b00, 16'h0A0B, 4'd4},  // R4
        {1'b0, 1'b1, 10'd6, 16'h0000, 2'b00, 16'h0000, 4'd4},  // R4 other half intact
        {1'b1, 1'b1, 10'd5, 16'h0102, 2'b00, 16'h0000, 4'd4},
        {1'b0, 1'b1, 10'd4, 16'h0000, 2'b00, 16'h0102, 4'd4},  // R4 addr bit0 ignored
        {1'b1, 1'b1, 10'd6, 16'h0300, 2'b01, 16'h0000, 4'd10},
        {1'b1, 1'b1, 10'd6, 16'h0507, 2'b01, 16'h0000, 4'd10},
        {1'b0, 1'b1, 10'd6, 16'h0000, 2'b00, 16'h0307, 4'd10}, // R10 lanes split
        {1'b1, 1'b1, 10'd4, 16'h0008, 2'b10, 16'h0000, 4'd10},
        {1'b0, 1'b1, 10'd4, 16'h0000, 2'b00, 16'h0108, 4'd10}  // R10 R5
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue a request at a negedge; return at the negedge after completion.
    task automatic do_op(input logic wr, input logic wd, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [1:0] m);
        req_valid = 1'b1; req_write = wr; req_word = wd;
        req_addr = a; req_wdata = d; prio_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 16'(busy), 16'h0);
        check("R1 done", 16'(done), 16'h0);
        check("R1 rdata", rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            do_op(TV[k][49], TV[k][48], TV[k][47:38], TV[k][37:22], TV[k][21:20]);
            if (!TV[k][49]) begin
                check($sformatf("R%0d table entry %0d", TV[k][3:0], k), rdata, TV[k][19:4]);
            end
        end

        // R2 timing and request held through busy window is ignored
        req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1;
        req_addr = 10'd4; req_wdata = 16'h0F0F; prio_mode = 2'b00;
        @(negedge clk);
        check("R2 busy after accept", 16'(busy), 16'h1);
        req_addr = 10'd6; req_wdata = 16'h0E0E;
        @(negedge clk);
        check("R2 busy second cycle", 16'(busy), 16'h1);
        check("R2 no early done", 16'(done), 16'h0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 busy falls", 16'(busy), 16'h0);
        check("R2 done pulse", 16'(done), 16'h1);
        @(negedge clk);
        check("R2 done one cycle", 16'(done), 16'h0);
        do_op(1'b0, 1'b1, 10'd6, 16'h0000, 2'b00);
        check("R2 held request ignored", rdata, 16'h0307);
        do_op(1'b0, 1'b1, 10'd4, 16'h0000, 2'b00);
        check("R2 first request done", rdata, 16'h0F0F);

        // R11 writes leave rdata unchanged
        do_op(1'b1, 1'b0, 10'd5, 16'h0001, 2'b00);
        check("R11 rdata held", rdata, 16'h0F0F);
        // R3 upper nibble of byte ignored, neighbour intact
        do_op(1'b0, 1'b0, 10'd5, 16'h0000, 2'b00);
        check("R3 byte lane", rdata, 16'h0001);
        do_op(1'b0, 1'b0, 10'd4, 16'h0000, 2'b00);
        check("R3 neighbour intact", rdata, 16'h000F);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule